// File: doc/BRIEF.md
# 16-bit Execute ALU with Flag Register

This block is the arithmetic and logic unit of a 16-bit pipelined processor's execute stage. Each cycle it takes an 8-bit operation code, two register operands (A from the destination-register read port, B from the source-register read port) and a 16-bit immediate. It produces a 16-bit result combinationally in the same cycle.

The block also holds a carry/zero/sign flag register. A valid strobe marks a cycle that executes an instruction. On such a cycle, zero and sign capture the new result at the next rising clock edge. Carry is written only by the two single-bit shifts and keeps its value on every other operation. When the strobe is low, all three flags hold.

Operation codes are decoded by range, so every byte selects some function. The design has no sequencing. Its only state is the flag register, which has two named states: "hold" when the load enable is low or the operation does not own the flag, and "load" when the flag takes its new value.

Top module: `alu16_flags`

## Requirements
- R1: While rst_n is low, carry_o, zero_o and sign_o are all 0.
- R2: Op codes 0x00 to 0x10 give A+B. Op codes 0x11 and 0x16 to 0x1F give A-B, where 0x16 is the compare form. Results are taken modulo 2^16.
- R3: Op code 0x12 gives A+1 and op code 0x13 gives A-1, both wrapping at 16 bits.
- R4: Op code 0x14 gives A shifted right by one with bit 15 cleared, and on a valid cycle carry becomes old A bit 0. Op code 0x15 gives A shifted left by one with bit 0 cleared, and on a valid cycle carry becomes old A bit 15.
- R5: Op code 0x20 gives A AND B, 0x21 gives A OR B, 0x22 gives A XOR B, and 0x23 to 0x2F give NOT A.
- R6: Op codes 0x30 to 0x3F and 0x60 to 0xFF pass B. Op codes 0x40 to 0x4F pass the immediate. Op codes 0x50 to 0x5F give the immediate's low byte in bits 15:8, with bits 7:0 zero.
- R7: After a valid cycle, zero_o is 1 exactly when that cycle's result was 0.
- R8: After a valid cycle, sign_o equals bit 15 of that cycle's result.
- R9: A valid cycle whose op code is not 0x14 or 0x15 leaves carry_o unchanged.
- R10: A cycle with valid_i low leaves all three flags unchanged, whatever the op code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| valid_i | input | 1 | Executed-instruction strobe; flag load enable |
| op_i | input | 8 | Operation code |
| a_i | input | 16 | Operand A (destination-register port) |
| b_i | input | 16 | Operand B (source-register port) |
| imm_i | input | 16 | Immediate operand |
| result_o | output | 16 | Combinational result |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |

## Verification
The hardest condition to reach is a carry that must survive a long run of other operations. It has to be set by a shift with the right operand bit, and then must not be disturbed by many valid non-shift cycles or by shifts issued with the strobe low. Random op bytes rarely land on 0x14 or 0x15, and a shifted-out bit of 1 is rarer still. Directed sequences therefore set carry with a chosen A and then issue other ops. Random stimulus also covers the gap op codes, where ranges decide the function. A reference model in the bench tracks carry across the whole run.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    typedef enum logic [3:0] {
        FN_ADD,
        FN_SUB,
        FN_INC,
        FN_DEC,
        FN_SHR,
        FN_SHL,
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_NOT,
        FN_PASS_B,
        FN_PASS_IMM,
        FN_IMM_HI
    } alu_fn_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
    } alu_flags_t;
endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
    import alu16_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] op_i,
    output alu_fn_e         fn_o
);
    // Range decode: each op byte maps to exactly one function
    always_comb begin
        if (op_i < OP_W'(8'h11))       fn_o = FN_ADD;
        else if (op_i == OP_W'(8'h11)) fn_o = FN_SUB;
        else if (op_i == OP_W'(8'h12)) fn_o = FN_INC;
        else if (op_i == OP_W'(8'h13)) fn_o = FN_DEC;
        else if (op_i == OP_W'(8'h14)) fn_o = FN_SHR;
        else if (op_i == OP_W'(8'h15)) fn_o = FN_SHL;
        else if (op_i < OP_W'(8'h20))  fn_o = FN_SUB;
        else if (op_i == OP_W'(8'h20)) fn_o = FN_AND;
        else if (op_i == OP_W'(8'h21)) fn_o = FN_OR;
        else if (op_i == OP_W'(8'h22)) fn_o = FN_XOR;
        else if (op_i < OP_W'(8'h30))  fn_o = FN_NOT;
        else if (op_i < OP_W'(8'h40))  fn_o = FN_PASS_B;
        else if (op_i < OP_W'(8'h50))  fn_o = FN_PASS_IMM;
        else if (op_i < OP_W'(8'h60))  fn_o = FN_IMM_HI;
        else                           fn_o = FN_PASS_B;
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e           fn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] imm_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              cown_o
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        cout_o = 1'b0;
        cown_o = 1'b0;
        unique case (fn_i)
            FN_ADD:      res_o = a_i + b_i;
            FN_SUB:      res_o = a_i - b_i;
            FN_INC:      res_o = a_i + DATA_W'(1);
            FN_DEC:      res_o = a_i - DATA_W'(1);
            FN_SHR: begin
                res_o  = a_i >> 1;
                cout_o = a_i[0];
                cown_o = 1'b1;
            end
            FN_SHL: begin
                res_o  = a_i << 1;
                cout_o = a_i[DATA_W-1];
                cown_o = 1'b1;
            end
            FN_AND:      res_o = a_i & b_i;
            FN_OR:       res_o = a_i | b_i;
            FN_XOR:      res_o = a_i ^ b_i;
            FN_NOT:      res_o = ~a_i;
            FN_PASS_B:   res_o = b_i;
            FN_PASS_IMM: res_o = imm_i;
            FN_IMM_HI:   res_o = imm_i << HALF;
            default:     res_o = b_i;
        endcase
    end
endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       cown_i,
    input  alu_flags_t next_i,
    output alu_flags_t flags_o
);
    typedef enum logic { ST_HOLD, ST_LOAD } upd_e;

    upd_e zs_upd, c_upd;

    always_comb begin
        zs_upd = load_i ? ST_LOAD : ST_HOLD;
        c_upd  = (load_i && cown_i) ? ST_LOAD : ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            unique case (zs_upd)
                ST_LOAD: begin
                    flags_o.z <= next_i.z;
                    flags_o.s <= next_i.s;
                end
                ST_HOLD: ;
            endcase
            unique case (c_upd)
                ST_LOAD: flags_o.c <= next_i.c;
                ST_HOLD: ;
            endcase
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(flags_o)); // R10
    AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !cown_i) |=> $stable(flags_o.c)); // R9
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] imm_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              zero_o,
    output logic              sign_o
);
    alu_fn_e    fn;
    logic       cout, cown;
    alu_flags_t nxt, cur;

    alu16_decode #(.OP_W(OP_W)) u_dec (
        .op_i (op_i),
        .fn_o (fn)
    );

    alu16_core #(.DATA_W(DATA_W)) u_core (
        .fn_i   (fn),
        .a_i    (a_i),
        .b_i    (b_i),
        .imm_i  (imm_i),
        .res_o  (result_o),
        .cout_o (cout),
        .cown_o (cown)
    );

    always_comb begin
        nxt.c = cout;
        nxt.z = (result_o == '0);
        nxt.s = result_o[DATA_W-1];
    end

    alu16_flagreg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (valid_i),
        .cown_i  (cown),
        .next_i  (nxt),
        .flags_o (cur)
    );

    assign carry_o = cur.c;
    assign zero_o  = cur.z;
    assign sign_o  = cur.s;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!carry_o && !zero_o && !sign_o)); // R1
    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (zero_o == ($past(result_o) == '0))); // R7
    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (sign_o == $past(result_o[DATA_W-1]))); // R8
    AST_SHR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_W'(8'h14)) |=> (carry_o == $past(a_i[0]))); // R4
    AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_W'(8'h15)) |=> (carry_o == $past(a_i[DATA_W-1]))); // R4
endmodule

// File: tb/test_alu16_flags.sv
`timescale 1ns/1ps
module test_alu16_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  op_i = '0;
    logic [15:0] a_i = '0, b_i = '0, imm_i = '0;
    logic [15:0] result_o;
    logic        carry_o, zero_o, sign_o;

    int n_vec = 0;
    int n_bad = 0;
    logic m_c = 1'b0, m_z = 1'b0, m_s = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    alu16_flags i_alu16_flags (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .result_o(result_o),
        .carry_o(carry_o), .zero_o(zero_o), .sign_o(sign_o)
    );

    function automatic logic [15:0] ref_res(logic [7:0] op, logic [15:0] a, logic [15:0] b, logic [15:0] im);
        if (op <= 8'h10) return a + b;                 // R2
        if (op == 8'h11) return a - b;                 // R2
        if (op == 8'h12) return a + 16'd1;             // R3
        if (op == 8'h13) return a - 16'd1;             // R3
        if (op == 8'h14) return {1'b0, a[15:1]};       // R4
        if (op == 8'h15) return {a[14:0], 1'b0};       // R4
        if (op <= 8'h1F) return a - b;                 // R2
        if (op == 8'h20) return a & b;                 // R5
        if (op == 8'h21) return a | b;                 // R5
        if (op == 8'h22) return a ^ b;                 // R5
        if (op <= 8'h2F) return ~a;                    // R5
        if (op <= 8'h3F) return b;                     // R6
        if (op <= 8'h4F) return im;                    // R6
        if (op <= 8'h5F) return {im[7:0], 8'h00};      // R6
        return b;                                      // R6
    endfunction

    function automatic string req_of(logic [7:0] op);
        if (op <= 8'h11 || (op >= 8'h16 && op <= 8'h1F)) return "R2";
        if (op == 8'h12 || op == 8'h13) return "R3";
        if (op == 8'h14 || op == 8'h15) return "R4";
        if (op >= 8'h20 && op <= 8'h2F) return "R5";
        return "R6";
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(logic v, logic [7:0] op, logic [15:0] a, logic [15:0] b, logic [15:0] im);
        logic [15:0] r;
        @(negedge clk);
        valid_i = v; op_i = op; a_i = a; b_i = b; imm_i = im;
        #1;
        r = ref_res(op, a, b, im);
        chk(req_of(op), result_o, r);
        if (v) begin
            m_z = (r == 16'h0);
            m_s = r[15];
            if (op == 8'h14) m_c = a[0];
            else if (op == 8'h15) m_c = a[15];
        end
        @(posedge clk); #1;
        chk(v ? ((op == 8'h14 || op == 8'h15) ? "R4" : "R9") : "R10", {15'd0, carry_o}, {15'd0, m_c});
        chk(v ? "R7" : "R10", {15'd0, zero_o}, {15'd0, m_z});
        chk(v ? "R8" : "R10", {15'd0, sign_o}, {15'd0, m_s});
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {13'd0, carry_o, zero_o, sign_o}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        apply(1, 8'h14, 16'h0003, 16'h0, 16'h0);   // R4 carry set by shr
        apply(1, 8'h10, 16'h1234, 16'h0001, 16'h0); // R9 carry held
        apply(1, 8'h20, 16'h0F0F, 16'hF0F0, 16'h0); // R5 and -> zero, R7
        apply(0, 8'h15, 16'h0000, 16'h0, 16'h0);   // R10 shift ignored
        apply(1, 8'h16, 16'h0005, 16'h0005, 16'h0); // R2 compare -> zero
        apply(1, 8'h15, 16'h8000, 16'h0, 16'h0);   // R4 shl carry, zero
        apply(1, 8'h15, 16'h4001, 16'h0, 16'h0);   // R4 shl clears carry, sign
        apply(1, 8'h12, 16'hFFFF, 16'h0, 16'h0);   // R3 wrap to zero
        apply(1, 8'h13, 16'h0000, 16'h0, 16'h0);   // R3 wrap to FFFF, R8
        apply(1, 8'h11, 16'h0001, 16'h0002, 16'h0); // R2 borrow
        apply(1, 8'h23, 16'h00FF, 16'h0, 16'h0);   // R5 not
        apply(1, 8'h2F, 16'hFFFF, 16'h0, 16'h0);   // R5 range end
        apply(1, 8'h5A, 16'h0, 16'h0, 16'h12AB);   // R6 immediate high
        apply(1, 8'h47, 16'h0, 16'h0, 16'h8001);   // R6 immediate
        apply(1, 8'h3C, 16'h0, 16'hBEEF, 16'h0);   // R6 pass B
        apply(1, 8'hFF, 16'h0, 16'h7777, 16'h0);   // R6 top op
        apply(1, 8'h00, 16'hFFFF, 16'h0001, 16'h0); // R2 low op wrap
        apply(1, 8'h1F, 16'h0010, 16'h0001, 16'h0); // R2 gap op

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] op;
            logic [15:0] a;
            if ($urandom_range(0, 3) == 0) op = 8'h14 + 8'($urandom_range(0, 1));
            else op = 8'($urandom_range(0, 255));
            a = 16'($urandom);
            if ($urandom_range(0, 4) == 0) a = 16'h0001;
            apply($urandom_range(0, 4) != 0, op, a, 16'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule